// File: doc/BRIEF.md
# Infrared Link Interrupt Status Hub

This block collects the event flags of an infrared link controller and turns them into a single interrupt line for the CPU. It keeps two event groups. One group serves the slow asynchronous transfer mode. The other serves the medium and fast modes. Each group has three registers behind a 16-bit register port:

- a sticky source register that latches one-cycle hardware strobes;
- a per-bit mask register;
- a write-one-to-clear register.

A transfer-mode register selects the mode. It also carries a second layer of masks, one bit per event group plus one bit for a FIFO receive request.

Two source bit positions mean different events depending on the mode. In slow mode, bit 9 reports a receive timeout and bit 8 a framing error. In medium and fast modes, the same positions report an abort and a CRC error. Software reads the source register, then writes the same value to the clear register to acknowledge. The interrupt line is registered. It reflects the register state one clock after that state exists.

Top module: `irlink_irq_hub`

## Requirements
- R1: Event strobe inputs map to source bits as follows: index 0 to bit 7 (frame transmitted), index 1 to bit 8 (framing error / CRC error), index 2 to bit 9 (receive timeout / abort), index 3 to bit 11 (transfer area overflow), and index 4 to bit 15 (frame received). A strobe sets its bit at the next clock edge, and the bit stays set until it is cleared.
- R2: Writing a 1 to a bit of a group's clear register clears that source bit at the next edge. A 0 leaves the bit unchanged. The clear registers always read as 0.
- R3: When a strobe and a clear write hit the same bit in the same cycle, the bit ends up set.
- R4: Source registers read the raw status whatever the masks hold. Bit positions other than 15, 11, 9, 8 and 7 read 0. Writes to a source address have no effect.
- R5: Per-bit mask registers reset to 0x8B80. Only bits 15, 11, 9, 8 and 7 are writable. A 1 masks the bit.
- R6: The mode register holds the mode field in bits 15:14 (00 slow, 11 medium, 10 fast) and the mask bits 0 (slow group), 4 (medium/fast group) and 8 (FIFO request). It resets to 0x0111, and its other bits read 0.
- R7: A write of 01 to the mode field leaves the field unchanged, while the mask bits of that write still take effect.
- R8: `irq_o` is high one clock after a cycle in which at least one of these holds:
  - a group has a source bit set whose per-bit mask is 0, while that group's mask bit in the mode register is 0;
  - `fifo_rx_req_i` is high while mode-register bit 8 is 0.
- R9: `fifo_rx_req_i` has no effect on `irq_o` while mode-register bit 8 is 1.
- R10: `xfer_mode_o` shows the current mode field.
- R11: The register map is as follows. Word address 0 is the mode register. Addresses 2, 3 and 4 are the slow group's source, mask and clear registers. Addresses 8, 9 and 10 are the medium/fast group's source, mask and clear registers. All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_addr_i | input | 4 | Register word address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| evt_slow_i | input | 5 | Slow-group event strobes |
| evt_fast_i | input | 5 | Medium/fast-group event strobes |
| fifo_rx_req_i | input | 1 | FIFO receive request level |
| xfer_mode_o | output | 2 | Current transfer-mode field |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach from the ports is a clear write that lands on the same edge as a strobe for the same bit. Software can only issue it blind, because the source register has not yet shown the new event. The stimulus builds this case on purpose, and it also arises often in a long pseudo-random phase. That phase mixes register writes at any address with strobes on both groups and the FIFO request, so mask layers often open and close while sources change. A behavioural model checks read data, the mode output and the interrupt line on every cycle.

// File: rtl/irlink_irq_pkg.sv
package irlink_irq_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 4;
    localparam int NUM_EVT = 5;
    localparam int NUM_GRP = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // Event strobe index to source bit position
    function automatic int evt_pos(input int k);
        case (k)
            0:       return 7;
            1:       return 8;
            2:       return 9;
            3:       return 11;
            default: return 15;
        endcase
    endfunction

    function automatic word_t evt_bits();
        word_t v;
        v = '0;
        for (int k = 0; k < NUM_EVT; k++) v[evt_pos(k)] = 1'b1;
        return v;
    endfunction

    localparam word_t EVT_MASK = evt_bits();

    typedef enum logic [1:0] {
        XM_SLOW = 2'b00,
        XM_RSVD = 2'b01,
        XM_FAST = 2'b10,
        XM_MED  = 2'b11
    } xfer_mode_e;

    localparam int MODE_LSB     = 14;
    localparam int GM_SLOW_BIT  = 0;
    localparam int GM_FAST_BIT  = 4;
    localparam int GM_FIFO_BIT  = 8;

    localparam addr_t A_MODE = addr_t'(0);

    function automatic addr_t grp_src_addr(input int g);
        return (g == 0) ? addr_t'(2) : addr_t'(8);
    endfunction

    typedef struct packed {
        word_t src;
        word_t msk;
    } grp_regs_t;

    typedef struct packed {
        xfer_mode_e mode;
        logic       gm_slow;
        logic       gm_fast;
        logic       gm_fifo;
    } mode_regs_t;

endpackage

// File: rtl/irlink_evt_group.sv
module irlink_evt_group
    import irlink_irq_pkg::*;
#(
    parameter int N_EVT = NUM_EVT
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_EVT-1:0] evt_i,
    input  logic             msk_we_i,
    input  logic             clr_we_i,
    input  word_t            wdata_i,
    output word_t            src_o,
    output word_t            msk_o,
    output logic             pend_o
);

    grp_regs_t regs_d, regs_q;
    word_t     set_vec;
    word_t     clr_vec;

    always_comb begin
        set_vec = '0;
        for (int k = 0; k < N_EVT; k++) begin
            set_vec[evt_pos(k)] = set_vec[evt_pos(k)] | evt_i[k];
        end
        clr_vec = clr_we_i ? (wdata_i & EVT_MASK) : '0;
        regs_d     = regs_q;
        regs_d.src = (regs_q.src & ~clr_vec) | set_vec;
        if (msk_we_i) regs_d.msk = wdata_i & EVT_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.src <= '0;
            regs_q.msk <= EVT_MASK;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign src_o  = regs_q.src;
    assign msk_o  = regs_q.msk;
    assign pend_o = |(regs_q.src & ~regs_q.msk);

    for (genvar k = 0; k < N_EVT; k++) begin : g_chk
        localparam int P = evt_pos(k);

        assert_evt_sets_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt_i[k] |=> src_o[P]);

        assert_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (src_o[P] && !(clr_we_i && wdata_i[P])) |=> src_o[P]);

        assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_we_i && wdata_i[P] && !evt_i[k]) |=> !src_o[P]);

        assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_we_i && wdata_i[P] && evt_i[k]) |=> src_o[P]);
    end

endmodule

// File: rtl/irlink_mode_reg.sv
module irlink_mode_reg
    import irlink_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       we_i,
    input  word_t      wdata_i,
    output mode_regs_t mode_o,
    output word_t      rd_o
);

    mode_regs_t mode_d, mode_q;
    xfer_mode_e wmode;

    always_comb begin
        wmode  = xfer_mode_e'(wdata_i[MODE_LSB +: 2]);
        mode_d = mode_q;
        if (we_i) begin
            if (wmode != XM_RSVD) mode_d.mode = wmode;
            mode_d.gm_slow = wdata_i[GM_SLOW_BIT];
            mode_d.gm_fast = wdata_i[GM_FAST_BIT];
            mode_d.gm_fifo = wdata_i[GM_FIFO_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q.mode    <= XM_SLOW;
            mode_q.gm_slow <= 1'b1;
            mode_q.gm_fast <= 1'b1;
            mode_q.gm_fifo <= 1'b1;
        end else begin
            mode_q <= mode_d;
        end
    end

    always_comb begin
        rd_o                  = '0;
        rd_o[MODE_LSB +: 2]   = mode_q.mode;
        rd_o[GM_SLOW_BIT]     = mode_q.gm_slow;
        rd_o[GM_FAST_BIT]     = mode_q.gm_fast;
        rd_o[GM_FIFO_BIT]     = mode_q.gm_fifo;
    end

    assign mode_o = mode_q;

    assert_rsvd_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && wdata_i[MODE_LSB +: 2] == 2'b01) |=> $stable(mode_o.mode));

    assert_mode_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && wdata_i[MODE_LSB +: 2] != 2'b01)
            |=> (rd_o[MODE_LSB +: 2] == $past(wdata_i[MODE_LSB +: 2])));

endmodule

// File: rtl/irlink_irq_hub.sv
module irlink_irq_hub
    import irlink_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [NUM_EVT-1:0] evt_slow_i,
    input  logic [NUM_EVT-1:0] evt_fast_i,
    input  logic              fifo_rx_req_i,
    output logic [1:0]        xfer_mode_o,
    output logic              irq_o
);

    typedef struct packed {
        logic irq;
    } out_regs_t;

    word_t        grp_src  [NUM_GRP];
    word_t        grp_msk  [NUM_GRP];
    logic [NUM_GRP-1:0] grp_pend;
    logic [NUM_GRP-1:0] grp_gate;
    logic [NUM_EVT-1:0] grp_evt [NUM_GRP];
    mode_regs_t   mode;
    word_t        mode_rd;
    out_regs_t    out_d, out_q;

    assign grp_evt[0] = evt_slow_i;
    assign grp_evt[1] = evt_fast_i;

    irlink_mode_reg u_mode (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (reg_we_i && reg_addr_i == A_MODE),
        .wdata_i (reg_wdata_i),
        .mode_o  (mode),
        .rd_o    (mode_rd)
    );

    assign grp_gate[0] = mode.gm_slow;
    assign grp_gate[1] = mode.gm_fast;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam addr_t SRC_A = grp_src_addr(g);
        localparam addr_t MSK_A = addr_t'(SRC_A + addr_t'(1));
        localparam addr_t CLR_A = addr_t'(SRC_A + addr_t'(2));

        irlink_evt_group #(.N_EVT(NUM_EVT)) u_grp (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .evt_i    (grp_evt[g]),
            .msk_we_i (reg_we_i && reg_addr_i == MSK_A),
            .clr_we_i (reg_we_i && reg_addr_i == CLR_A),
            .wdata_i  (reg_wdata_i),
            .src_o    (grp_src[g]),
            .msk_o    (grp_msk[g]),
            .pend_o   (grp_pend[g])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == A_MODE) reg_rdata_o = mode_rd;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (reg_addr_i == grp_src_addr(g))                       reg_rdata_o = grp_src[g];
            if (reg_addr_i == addr_t'(grp_src_addr(g) + addr_t'(1))) reg_rdata_o = grp_msk[g];
        end
    end

    always_comb begin
        out_d     = out_q;
        out_d.irq = (|(grp_pend & ~grp_gate)) | (fifo_rx_req_i & ~mode.gm_fifo);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign irq_o       = out_q.irq;
    assign xfer_mode_o = mode.mode;

    assert_all_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode.gm_slow && mode.gm_fast && mode.gm_fifo) |=> !irq_o);

    assert_fifo_open_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fifo_rx_req_i && !mode.gm_fifo) |=> irq_o);

    assert_grp_open_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grp_pend[0] && !mode.gm_slow) |=> irq_o);

endmodule

// File: tb/irlink_irq_hub_tb_top.sv
`timescale 1ns/1ps
module irlink_irq_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        we = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [4:0]  es = '0;
    logic [4:0]  ef = '0;
    logic        fifo = 1'b0;
    logic [1:0]  xmode;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    irlink_irq_hub dut_i (
        .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_slow_i(es),
        .evt_fast_i(ef), .fifo_rx_req_i(fifo), .xfer_mode_o(xmode), .irq_o(irq)
    );

    // behavioural reference model
    logic [15:0] m_src [2];
    logic [15:0] m_msk [2];
    logic [15:0] m_mode;
    logic        m_irq;

    function automatic logic [15:0] spread(input logic [4:0] e);
        logic [15:0] v = 16'h0;
        if (e[0]) v = v | 16'h0080;
        if (e[1]) v = v | 16'h0100;
        if (e[2]) v = v | 16'h0200;
        if (e[3]) v = v | 16'h0800;
        if (e[4]) v = v | 16'h8000;
        return v;
    endfunction

    function automatic logic [15:0] m_read(input logic [3:0] a);
        case (a)
            4'd0: return m_mode;
            4'd2: return m_src[0];
            4'd3: return m_msk[0];
            4'd8: return m_src[1];
            4'd9: return m_msk[1];
            default: return 16'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R6/R7";
            4'd2, 4'd8: return "R1/R3/R4";
            4'd3, 4'd9: return "R5";
            4'd4, 4'd10: return "R2";
            default: return "R11";
        endcase
    endfunction

    task automatic m_reset();
        m_src[0] = 16'h0; m_src[1] = 16'h0;
        m_msk[0] = 16'h8B80; m_msk[1] = 16'h8B80;
        m_mode = 16'h0111; m_irq = 1'b0;
    endtask

    task automatic m_step();
        logic [15:0] set_v;
        logic        nirq;
        nirq = ((m_src[0] & ~m_msk[0]) != 0 && !m_mode[0]) ||
               ((m_src[1] & ~m_msk[1]) != 0 && !m_mode[4]) ||
               (fifo && !m_mode[8]);
        for (int g = 0; g < 2; g++) begin
            set_v = spread(g == 0 ? es : ef);
            if (we && addr == (g == 0 ? 4'd4 : 4'd10)) m_src[g] = m_src[g] & ~(wdata & 16'h8B80);
            m_src[g] = m_src[g] | set_v;
            if (we && addr == (g == 0 ? 4'd3 : 4'd9)) m_msk[g] = wdata & 16'h8B80;
        end
        if (we && addr == 4'd0) begin
            logic [1:0] nm;
            nm = (wdata[15:14] == 2'b01) ? m_mode[15:14] : wdata[15:14];
            m_mode = {nm, 14'h0} | (wdata & 16'h0111);
        end
        m_irq = nirq;
    endtask

    task automatic compare();
        n_chk++;
        if (rdata !== m_read(addr)) begin
            n_bad++;
            $display("FAIL %s: read addr %0d actual %h expected %h", tag_of(addr), addr, rdata, m_read(addr));
        end
        n_chk++;
        if (irq !== m_irq) begin
            n_bad++;
            $display("FAIL R8/R9: irq_o actual %b expected %b", irq, m_irq);
        end
        n_chk++;
        if (xmode !== m_mode[15:14]) begin
            n_bad++;
            $display("FAIL R10: xfer_mode_o actual %b expected %b", xmode, m_mode[15:14]);
        end
    endtask

    task automatic cyc(input logic [3:0] a, input logic w, input logic [15:0] d,
                       input logic [4:0] s, input logic [4:0] f, input logic q);
        @(negedge clk);
        compare();
        addr = a; we = w; wdata = d; es = s; ef = f; fifo = q;
        @(posedge clk);
        m_step();
    endtask

    task automatic idle(input logic [3:0] a);
        cyc(a, 1'b0, 16'h0, 5'h0, 5'h0, 1'b0);
    endtask

    initial begin
        logic [31:0] lfsr;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // reset state, every address (R5, R6, R11)
        for (int a = 0; a < 16; a++) idle(4'(a));
        // R1: slow events with slow group opened
        cyc(4'd3, 1'b1, 16'hFFFF, 5'h0, 5'h0, 1'b0);
        cyc(4'd0, 1'b1, 16'hFFFE, 5'h0, 5'h0, 1'b0);
        cyc(4'd2, 1'b0, 16'h0, 5'b00001, 5'h0, 1'b0);
        idle(4'd2); idle(4'd2);
        // R5: unmask all slow bits, irq rises (R8)
        cyc(4'd3, 1'b1, 16'h0000, 5'b01010, 5'h0, 1'b0);
        idle(4'd2); idle(4'd2);
        // R2: clear one bit, zero bits untouched
        cyc(4'd4, 1'b1, 16'h0080, 5'h0, 5'h0, 1'b0);
        idle(4'd2); idle(4'd4);
        // R3: clear and strobe on same bit in the same cycle
        cyc(4'd4, 1'b1, 16'h8B80, 5'b10000, 5'h0, 1'b0);
        idle(4'd2); idle(4'd2);
        // R4: write to source address ignored
        cyc(4'd2, 1'b1, 16'hFFFF, 5'h0, 5'h0, 1'b0);
        idle(4'd2);
        cyc(4'd4, 1'b1, 16'hFFFF, 5'h0, 5'h0, 1'b0);
        idle(4'd2); idle(4'd2);
        // medium mode, fast group
        cyc(4'd0, 1'b1, 16'hC001, 5'h0, 5'h0, 1'b0);
        cyc(4'd9, 1'b1, 16'h0000, 5'h0, 5'b00110, 1'b0);
        idle(4'd8); idle(4'd8);
        // R7: reserved mode code keeps field, masks apply
        cyc(4'd0, 1'b1, 16'h4111, 5'h0, 5'h0, 1'b0);
        idle(4'd0); idle(4'd0);
        cyc(4'd0, 1'b1, 16'h8000, 5'h0, 5'h0, 1'b0);
        idle(4'd0);
        // R9: fifo request gated by bit 8
        cyc(4'd10, 1'b1, 16'hFFFF, 5'h0, 5'h0, 1'b0);
        cyc(4'd0, 1'b1, 16'h0111, 5'h0, 5'h0, 1'b1);
        idle(4'd0);
        cyc(4'd0, 1'b0, 16'h0, 5'h0, 5'h0, 1'b1);
        cyc(4'd0, 1'b1, 16'h0011, 5'h0, 5'h0, 1'b1);
        cyc(4'd0, 1'b0, 16'h0, 5'h0, 5'h0, 1'b1);
        idle(4'd0); idle(4'd0);
        // pseudo-random mix
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[3:0], lfsr[4] & lfsr[5], lfsr[31:16],
                lfsr[10:6] & lfsr[15:11], lfsr[15:11] & lfsr[20:16], lfsr[12] & lfsr[13]);
        end
        idle(4'd0);
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule